// File: doc/BRIEF.md
# Two-Level Longest-Prefix Route Lookup

This block turns a 32-bit IPv4 destination address into an output port number, using longest-prefix-match semantics. The control processor expands the routes in software and writes them into two on-chip tables. The first-level table is indexed directly by the address bits just above bit 8. Each of its entries holds either a final port number or a pointer to a 256-entry block of the second-level table. That second table holds the rare routes longer than 24 bits. It is indexed by the block pointer joined with address bits [7:0].

Prefixes of 24 bits or fewer resolve with one table read. Longer prefixes take exactly two reads. The pipeline accepts a new address on every clock and returns the caller's tag with each result. The only exception is a one-cycle pause after a request that goes on to the second level. There is no default route, so an address whose entry was never written comes back with an explicit miss flag. In this build the tables are scaled down: the first level decodes `L1_W` index bits (bits [15:8] by default), and the address bits above that field are not decoded.

Top module: `route_lkup`

## Requirements
- R1: A first-level entry is selected by address bits [8+L1_W-1:8]. When its pointer flag is clear, `resp_valid` rises exactly 2 cycles after the request is accepted, with `resp_port` equal to the stored port and `resp_miss` low.
- R2: When the selected first-level entry has its pointer flag set, the second-level entry at index {block, address[7:0]} is read. The response appears exactly 3 cycles after acceptance, carrying that entry's port.
- R3: If the first-level entry has never been written since reset, the response arrives 2 cycles after acceptance with `resp_miss` high and `resp_port` zero.
- R4: If the first-level entry points to a second-level entry that has never been written, the response arrives 3 cycles after acceptance with `resp_miss` high and `resp_port` zero.
- R5: Every response carries the `req_tag` of the request it answers.
- R6: Requests that resolve at the first level can be accepted on consecutive cycles. Their responses then come out on consecutive cycles, in request order.
- R7: `req_ready` is low for exactly the one cycle after a request whose first-level entry is a pointer was accepted, and high at every other time. This keeps two responses from ever falling in the same cycle.
- R8: A write issued in the same cycle as the table read of that entry does not affect that lookup, which returns the old value. Later lookups return the new value. This holds for both tables.
- R9: After reset, `resp_valid` is low, `req_ready` is high and every table entry reads as a miss.
- R10: Address bits above the first-level field do not change the result. A shorter prefix is served by writing the same port into every first-level entry it covers.
- R11: With `wr_sel` = 0 a write stores {`wr_ptr`, `wr_value`} at first-level index `wr_index`[L1_W-1:0]. With `wr_sel` = 1 it stores `wr_value`[PORT_W-1:0] at second-level index `wr_index` = {block, low byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | 32 | Destination address |
| req_tag | input | TAG_W | Caller tag, returned with the result |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 selects the first-level table, 1 the second-level table |
| wr_index | input | max(L1_W, BLK_W+8) | Entry index of the write |
| wr_ptr | input | 1 | First-level pointer flag |
| wr_value | input | max(PORT_W, BLK_W) | Port number, or block number when `wr_ptr` is set |
| resp_valid | output | 1 | Result present |
| resp_tag | output | TAG_W | Tag of the answered request |
| resp_port | output | PORT_W | Output port, zero on a miss |
| resp_miss | output | 1 | No route found |

## Verification
The timing properties assume that `req_valid` is low while reset is held. They also assume the caller counts a request as taken only in a cycle where `req_ready` is high. The bench drives every request on the falling edge and holds it until `req_ready` is seen high. It keeps `req_valid` low throughout reset. A request may be refused because `req_ready` is low, and the bench exercises that case. The request is then still accepted on the following cycle, so the latency and tag checks stay exact.

// File: rtl/route_lkup_pkg.sv
package route_lkup_pkg;
    // Address bits below the first-level field; they index inside a second-level block
    localparam int LO_W = 8;

    typedef enum logic {
        TBL_FIRST  = 1'b0,
        TBL_SECOND = 1'b1
    } tbl_sel_e;
endpackage

// File: rtl/route_lkup_table.sv
// Synchronous-read table with one valid bit per entry, cleared at reset.
// A read that coincides with a write to the same entry returns the old data.
module route_lkup_table #(
    parameter int AW = 8,
    parameter int DW = 5,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_hit
);
    logic [DW-1:0]    mem_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DW-1:0]    rd_data_q;
    logic             rd_hit_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        rd_data_q <= mem_q[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q    <= '0;
            rd_hit_q <= 1'b0;
        end else begin
            if (wr_en) begin
                vld_q[wr_addr] <= 1'b1;
            end
            rd_hit_q <= vld_q[rd_addr];
        end
    end

    assign rd_data = rd_data_q;
    assign rd_hit  = rd_hit_q;
endmodule

// File: rtl/route_lkup_decode.sv
// Interprets a first-level entry: a final port or a second-level block pointer.
module route_lkup_decode #(
    parameter int PORT_W = 4,
    parameter int BLK_W  = 3,
    parameter int PAY_W  = 4
) (
    input  logic              live,
    input  logic              hit,
    input  logic [PAY_W:0]    entry,
    output logic              is_ptr,
    output logic              is_leaf,
    output logic              leaf_miss,
    output logic [PORT_W-1:0] leaf_port,
    output logic [BLK_W-1:0]  blk
);
    always_comb begin
        is_ptr    = live & hit & entry[PAY_W];
        is_leaf   = live & ~is_ptr;
        leaf_miss = ~hit;
        leaf_port = hit ? entry[PORT_W-1:0] : '0;
        blk       = entry[BLK_W-1:0];
    end
endmodule

// File: rtl/route_lkup.sv
module route_lkup
    import route_lkup_pkg::*;
#(
    parameter int  PORT_W = 4,
    parameter int  TAG_W  = 4,
    parameter int  L1_W   = 8,
    parameter int  BLK_W  = 3,
    localparam int L2_AW  = BLK_W + LO_W,
    localparam int IDX_W  = (L1_W > L2_AW) ? L1_W : L2_AW,
    localparam int PAY_W  = (PORT_W > BLK_W) ? PORT_W : BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic              wr_ptr,
    input  logic [PAY_W-1:0]  wr_value,
    output logic              resp_valid,
    output logic [TAG_W-1:0]  resp_tag,
    output logic [PORT_W-1:0] resp_port,
    output logic              resp_miss
);
    typedef struct packed {
        logic              s1_v;
        logic [TAG_W-1:0]  s1_tag;
        logic [LO_W-1:0]   s1_lo;
        logic              s2_v;
        logic [TAG_W-1:0]  s2_tag;
        logic              out_v;
        logic [TAG_W-1:0]  out_tag;
        logic [PORT_W-1:0] out_port;
        logic              out_miss;
    } state_t;

    state_t st_d, st_q;

    logic              l1_we, l2_we;
    logic [PAY_W:0]    l1_entry;
    logic              l1_hit;
    logic [PORT_W-1:0] l2_entry;
    logic              l2_hit;
    logic              is_ptr, is_leaf, leaf_miss;
    logic [PORT_W-1:0] leaf_port;
    logic [BLK_W-1:0]  blk;
    logic [L2_AW-1:0]  l2_rd_addr;

    assign l1_we      = wr_en & (tbl_sel_e'(wr_sel) == TBL_FIRST);
    assign l2_we      = wr_en & (tbl_sel_e'(wr_sel) == TBL_SECOND);
    assign l2_rd_addr = {blk, st_q.s1_lo};

    route_lkup_table #(.AW(L1_W), .DW(PAY_W + 1)) u_first (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (l1_we),
        .wr_addr (wr_index[L1_W-1:0]),
        .wr_data ({wr_ptr, wr_value}),
        .rd_addr (req_addr[LO_W +: L1_W]),
        .rd_data (l1_entry),
        .rd_hit  (l1_hit)
    );

    route_lkup_decode #(.PORT_W(PORT_W), .BLK_W(BLK_W), .PAY_W(PAY_W)) u_dec (
        .live      (st_q.s1_v),
        .hit       (l1_hit),
        .entry     (l1_entry),
        .is_ptr    (is_ptr),
        .is_leaf   (is_leaf),
        .leaf_miss (leaf_miss),
        .leaf_port (leaf_port),
        .blk       (blk)
    );

    route_lkup_table #(.AW(L2_AW), .DW(PORT_W)) u_second (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (l2_we),
        .wr_addr (wr_index[L2_AW-1:0]),
        .wr_data (wr_value[PORT_W-1:0]),
        .rd_addr (l2_rd_addr),
        .rd_data (l2_entry),
        .rd_hit  (l2_hit)
    );

    // A pointer in stage 1 makes its result land one cycle late, so the
    // request slot behind it is withheld to keep the response port free.
    assign req_ready = ~is_ptr;

    always_comb begin
        st_d = st_q;

        st_d.s1_v   = req_valid & req_ready;
        st_d.s1_tag = req_tag;
        st_d.s1_lo  = req_addr[LO_W-1:0];

        st_d.s2_v   = is_ptr;
        st_d.s2_tag = st_q.s1_tag;

        st_d.out_v    = 1'b0;
        st_d.out_miss = 1'b0;
        st_d.out_port = '0;
        if (st_q.s2_v) begin
            st_d.out_v    = 1'b1;
            st_d.out_tag  = st_q.s2_tag;
            st_d.out_miss = ~l2_hit;
            st_d.out_port = l2_hit ? l2_entry : '0;
        end else if (is_leaf) begin
            st_d.out_v    = 1'b1;
            st_d.out_tag  = st_q.s1_tag;
            st_d.out_miss = leaf_miss;
            st_d.out_port = leaf_port;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.out_v;
    assign resp_tag   = st_q.out_tag;
    assign resp_port  = st_q.out_port;
    assign resp_miss  = st_q.out_miss;
endmodule

// File: rtl/route_lkup_chk.sv
module route_lkup_chk #(
    parameter int TAG_W  = 4,
    parameter int PORT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TAG_W-1:0]  req_tag,
    input logic              resp_valid,
    input logic [TAG_W-1:0]  resp_tag,
    input logic [PORT_W-1:0] resp_port,
    input logic              resp_miss
);
    logic acc;
    assign acc = req_valid & req_ready;

    a_r9_idle_out_of_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !resp_valid);

    a_r1_short_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc, 2) && $past(req_ready, 1))
        |-> (resp_valid && resp_tag == $past(req_tag, 2)));

    a_r2_long_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc, 3) && !$past(req_ready, 2))
        |-> (resp_valid && resp_tag == $past(req_tag, 3)));

    a_r7_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    a_r7_no_orphan_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (($past(acc, 2) && $past(req_ready, 1)) ||
                        ($past(acc, 3) && !$past(req_ready, 2))));

    a_r3_miss_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_miss) |-> (resp_port == '0));
endmodule

bind route_lkup route_lkup_chk #(.TAG_W(TAG_W), .PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_tag    (req_tag),
    .resp_valid (resp_valid),
    .resp_tag   (resp_tag),
    .resp_port  (resp_port),
    .resp_miss  (resp_miss)
);

// File: tb/route_lkup_tb_top.sv
module route_lkup_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_tag = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [10:0] wr_index = '0;
    logic        wr_ptr = 1'b0;
    logic [3:0]  wr_value = '0;
    logic        resp_valid;
    logic [3:0]  resp_tag;
    logic [3:0]  resp_port;
    logic        resp_miss;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    route_lkup dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_tag(req_tag), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_index(wr_index), .wr_ptr(wr_ptr), .wr_value(wr_value),
        .resp_valid(resp_valid), .resp_tag(resp_tag), .resp_port(resp_port),
        .resp_miss(resp_miss)
    );

    localparam int NV = 9;
    localparam logic [31:0] V_ADDR [NV] = '{
        32'hC0A8_1005, 32'h0A00_20FF, 32'h0A00_2100, 32'h0000_3040, 32'hFFFF_3041,
        32'h1234_3042, 32'h1234_4000, 32'hABCD_55FF, 32'hABCD_55FE};
    localparam logic [3:0] V_PORT [NV] = '{4'd3, 4'd5, 4'd5, 4'd9, 4'd7, 4'd0, 4'd0, 4'd1, 4'd0};
    localparam logic       V_MISS [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam int         V_LAT  [NV] = '{2, 2, 2, 3, 3, 3, 2, 3, 3};

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic twrite(input logic sel, input int idx, input logic ptr, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_index = idx[10:0]; wr_ptr = ptr; wr_value = val[3:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic [3:0] t, output int lat,
                          output logic [3:0] p, output logic m, output logic [3:0] rt);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_tag = t;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        p = resp_port; m = resp_miss; rt = resp_tag;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic [3:0] p, rt;
        logic m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle outputs after reset
        check("R9 resp_valid", resp_valid == 1'b0, resp_valid, 0);
        check("R9 req_ready", req_ready == 1'b1, req_ready, 1);
        // R9, R3: empty table gives a miss at latency 2
        lookup(32'h1234_1000, 4'd2, lat, p, m, rt);
        check("R3 empty miss", m == 1'b1 && p == 4'd0, {m, p}, 16);
        check("R3 empty latency", lat == 2, lat, 2);

        // R11: table load; second level uses index {block, low byte}
        twrite(1'b0, 8'h10, 1'b0, 3);
        twrite(1'b0, 8'h20, 1'b0, 5);    // R10: expanded prefix, duplicate entries
        twrite(1'b0, 8'h21, 1'b0, 5);
        twrite(1'b0, 8'h30, 1'b1, 2);
        twrite(1'b0, 8'h55, 1'b1, 0);
        twrite(1'b1, (2 << 8) | 8'h40, 1'b0, 9);
        twrite(1'b1, (2 << 8) | 8'h41, 1'b0, 7);
        twrite(1'b1, 8'hFF, 1'b0, 1);

        // R1, R2, R4, R5, R10: vector walk
        for (int i = 0; i < NV; i++) begin
            lookup(V_ADDR[i], i[3:0], lat, p, m, rt);
            check(V_LAT[i] == 2 ? "R1 port" : "R2 port", p == V_PORT[i], p, V_PORT[i]);
            check(V_LAT[i] == 2 ? "R3 miss flag" : "R4 miss flag", m == V_MISS[i], m, V_MISS[i]);
            check(V_LAT[i] == 2 ? "R1 latency" : "R2 latency", lat == V_LAT[i], lat, V_LAT[i]);
            check("R5 tag", rt == i[3:0], rt, i);
        end

        // R6: back-to-back first-level lookups
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_1000; req_tag = 4'd1;
        @(negedge clk);
        check("R6 ready", req_ready == 1'b1, req_ready, 1);
        req_addr = 32'h7777_2000; req_tag = 4'd2;
        @(negedge clk);
        check("R6 first resp", resp_valid && resp_tag == 4'd1 && resp_port == 4'd3,
              {resp_valid, resp_tag, resp_port}, 9'h113);
        req_addr = 32'h0000_4000; req_tag = 4'd3;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 second resp", resp_valid && resp_tag == 4'd2 && resp_port == 4'd5,
              {resp_valid, resp_tag, resp_port}, 9'h125);
        @(negedge clk);
        check("R6 third resp", resp_valid && resp_tag == 4'd3 && resp_miss,
              {resp_valid, resp_tag, resp_miss}, 6'h27);
        @(negedge clk);
        check("R6 drained", resp_valid == 1'b0, resp_valid, 0);

        // R7: pointer entry withholds the next slot for one cycle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_3040; req_tag = 4'd5;
        @(negedge clk);
        check("R7 stall", req_ready == 1'b0, req_ready, 0);
        req_addr = 32'h0000_1000; req_tag = 4'd6;
        @(negedge clk);
        check("R7 ready again", req_ready == 1'b1, req_ready, 1);
        check("R7 no early resp", resp_valid == 1'b0, resp_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 long resp", resp_valid && resp_tag == 4'd5 && resp_port == 4'd9,
              {resp_valid, resp_tag, resp_port}, 9'h159);
        @(negedge clk);
        check("R7 held resp", resp_valid && resp_tag == 4'd6 && resp_port == 4'd3,
              {resp_valid, resp_tag, resp_port}, 9'h163);

        // R8: first-level write coinciding with the read returns the old port
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_1000; req_tag = 4'd7;
        wr_en = 1'b1; wr_sel = 1'b0; wr_index = 11'h010; wr_ptr = 1'b0; wr_value = 4'd6;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check("R8 first old value", resp_valid && resp_port == 4'd3, resp_port, 3);
        lookup(32'h0000_1000, 4'd8, lat, p, m, rt);
        check("R8 first new value", p == 4'd6, p, 6);

        // R8: second-level write coinciding with the second read
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_3040; req_tag = 4'd9;
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_sel = 1'b1; wr_index = 11'h240; wr_value = 4'd11;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R8 second old value", resp_valid && resp_port == 4'd9, resp_port, 9);
        lookup(32'h0000_3040, 4'd10, lat, p, m, rt);
        check("R8 second new value", p == 4'd11, p, 11);

        // R11: a pointer entry rewritten as a port resolves at the first level
        twrite(1'b0, 8'h55, 1'b0, 4);
        lookup(32'h0000_55FF, 4'd11, lat, p, m, rt);
        check("R11 rewrite port", p == 4'd4, p, 4);
        check("R11 rewrite latency", lat == 2, lat, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule